// File: doc/BRIEF.md
# Bus Configuration and Pin Router for a Contactless Reader Front End

This block sits between the pins of a 125 kHz tag reader front end and its internal demodulator, antenna driver stage and diagnostic-line transmitter. Two mode-select pins pick one of three bus topologies. In the single-wire topology the K line carries demodulated data, and a separate protocol engine handles write and standby. In the two-wire topology the K line carries demodulated data and a modulation pin keys the antenna drivers. In the microcontroller topology, demodulated data leaves on a dedicated data pin, and the K line becomes a plain transmitter and receiver pair driven by `tx_i`.

For the two-wire and microcontroller topologies the block also owns low-power entry and exit. In the two-wire topology, holding the modulation pin low long enough requests standby. The block answers with a fixed-length acknowledge pulse on K, then parks the antenna drivers. In the microcontroller topology, the second mode pin acts directly as a run/standby control, and the antenna drivers freeze in place. Every wake-up returns the block to read mode and sends a one-cycle pulse to the carrier timer. A latch on the K transmitter keeps the driver off after a thermal fault until the fault clears and the driver request has gone off and then on again.

Every pin is a plain synchronous level, sampled on `clk`. No data stream crosses this block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `kbus_pin_router`

## Requirements
- R1: `mode1_i`=1 selects the microcontroller topology, and `mode2_i` is then the run/standby control. `mode1_i`=0 selects the two-wire topology when `mode2_i`=1 and the single-wire topology when `mode2_i`=0.
- R2: In the single-wire and two-wire topologies, `dout_o` and `rx_o` stay 0 in every cycle, and `tx_i` has no effect on any output.
- R3: `ant_mode_o` uses this encoding: 0 = drivers off, 1 = drivers on, 2 = parked (first driver low, second high), 3 = frozen at the last state. While running in the single-wire or two-wire topology, `k_drive_o` = NOT `demod_i` (1 pulls K dominant low). `ant_mode_o` is 1 in single-wire and follows `am_i` (1 when high, 0 when low) in two-wire.
- R4: In two-wire, once `am_i` has been low at STBY_CYC consecutive rising edges, the block sends an acknowledge: `k_drive_o`=1 and `ant_mode_o`=0 for ACK_CYC cycles, then standby. A low run of STBY_CYC-1 edges has no effect.
- R5: In two-wire standby, `stby_o`=1, `ant_mode_o`=2 and `k_drive_o`=0. A rising edge of `am_i` wakes the block.
- R6: While running in the microcontroller topology, `dout_o` = `demod_i`, `k_drive_o` = `tx_i`, `rx_o` = `k_rx_i`, and `ant_mode_o` follows `am_i` as in R3.
- R7: In the microcontroller topology, `mode2_i` low at a rising edge enters standby at that edge. In standby, `ant_mode_o`=3, `dout_o`=0, `k_drive_o`=0 whatever `tx_i` is, and `rx_o` still follows `k_rx_i`. `mode2_i` high at an edge wakes the block.
- R8: `therm_fault_i`=1 forces `k_drive_o` to 0 at once. After the fault clears, the driver stays off until the driver request has been 0 at a rising edge. After that, the driver follows the request again.
- R9: A wake-up clears `stby_o` at the waking edge and raises `wake_o` for exactly the following cycle. `wake_o` is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode1_i | input | 1 | First topology select pin |
| mode2_i | input | 1 | Second topology select / run control |
| am_i | input | 1 | Amplitude-modulation command level |
| tx_i | input | 1 | Transmitter command (microcontroller topology) |
| k_rx_i | input | 1 | Received level of the K line |
| demod_i | input | 1 | Demodulated tag data |
| therm_fault_i | input | 1 | K driver over-temperature flag |
| k_drive_o | output | 1 | K driver on (line dominant low) |
| dout_o | output | 1 | Demodulated data pin |
| rx_o | output | 1 | K line monitor pin |
| ant_mode_o | output | 2 | Antenna driver mode, encoded as in R3 |
| stby_o | output | 1 | Standby flag |
| wake_o | output | 1 | One-cycle wake pulse to the carrier timer |

## Verification
The hardest state to reach from the ports is the exact boundary of the two-wire standby request. A low run one edge short of the limit must leave the block running. A run of exactly the limit must start an acknowledge of exact length, and a rising edge of `am_i` in the middle of that acknowledge must not wake the block. The bench sets the limits small and holds `am_i` low for counted edges, with `demod_i` held so that the acknowledge is visible as a change on `k_drive_o`. A bench model, updated every edge, predicts every output in every cycle. The thermal re-arm is reached by raising the fault while `tx_i` requests drive, then clearing the fault with the request still high.

// File: rtl/kbus_rtr_pkg.sv
package kbus_rtr_pkg;
  typedef enum logic [1:0] {
    TOPO_SINGLE = 2'd0,
    TOPO_TWO    = 2'd1,
    TOPO_MCU    = 2'd2
  } topo_e;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,
    PWR_ACK   = 2'd1,
    PWR_SLEEP = 2'd2
  } pwr_e;

  typedef enum logic [1:0] {
    ANT_OFF    = 2'd0,
    ANT_ON     = 2'd1,
    ANT_PARK   = 2'd2,
    ANT_FREEZE = 2'd3
  } ant_e;
endpackage

// File: rtl/kbus_topo_decode.sv
module kbus_topo_decode
  import kbus_rtr_pkg::*;
(
  input  logic  mode1_i,
  input  logic  mode2_i,
  output topo_e topo_o
);
  always_comb begin
    if (mode1_i)      topo_o = TOPO_MCU;
    else if (mode2_i) topo_o = TOPO_TWO;
    else              topo_o = TOPO_SINGLE;
  end
endmodule

// File: rtl/kbus_power_fsm.sv
module kbus_power_fsm
  import kbus_rtr_pkg::*;
#(
  parameter int STBY_CYC = 16256,
  parameter int ACK_CYC  = 4096
) (
  input  logic  clk,
  input  logic  rst_n,
  input  topo_e topo_i,
  input  logic  am_i,
  input  logic  run_req_i,
  output pwr_e  pwr_o,
  output logic  wake_o
);
  localparam int MAXC = (STBY_CYC > ACK_CYC) ? STBY_CYC : ACK_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] STBY_LAST = CW'(STBY_CYC - 1);
  localparam logic [CW-1:0] ACK_LAST  = CW'(ACK_CYC - 1);

  pwr_e          st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          am_q, wake_q, wake_n;
  topo_e         topo_q;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    wake_n = 1'b0;
    if (st_q != PWR_RUN && topo_i != topo_q) begin
      st_n  = PWR_RUN;
      cnt_n = '0;
    end else begin
      unique case (st_q)
        PWR_RUN: begin
          if (topo_i == TOPO_TWO && !am_i) begin
            if (cnt_q == STBY_LAST) begin
              st_n  = PWR_ACK;
              cnt_n = '0;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end else begin
            cnt_n = '0;
            if (topo_i == TOPO_MCU && !run_req_i) st_n = PWR_SLEEP;
          end
        end
        PWR_ACK: begin
          if (cnt_q == ACK_LAST) begin
            st_n  = PWR_SLEEP;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        PWR_SLEEP: begin
          if ((topo_i == TOPO_TWO && am_i && !am_q) ||
              (topo_i == TOPO_MCU && run_req_i)) begin
            st_n   = PWR_RUN;
            wake_n = 1'b1;
          end
        end
        default: st_n = PWR_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= PWR_RUN;
      cnt_q  <= '0;
      am_q   <= 1'b1;
      wake_q <= 1'b0;
      topo_q <= TOPO_SINGLE;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      am_q   <= am_i;
      wake_q <= wake_n;
      topo_q <= topo_i;
    end
  end

  assign pwr_o  = st_q;
  assign wake_o = wake_q;

  AST_ACK_NEEDS_LOW_AM: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PWR_ACK && $past(st_q) == PWR_RUN) |-> $past(!am_i)); // R4
  AST_TWO_SLEEP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PWR_SLEEP && $past(st_q) != PWR_SLEEP && topo_i == TOPO_TWO && $past(topo_i) == TOPO_TWO)
      |-> $past(st_q) == PWR_ACK); // R4
  AST_WAKE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q); // R9
  AST_WAKE_MEANS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> (st_q == PWR_RUN && $past(st_q) == PWR_SLEEP)); // R9
endmodule

// File: rtl/kbus_pin_mux.sv
module kbus_pin_mux
  import kbus_rtr_pkg::*;
(
  input  topo_e      topo_i,
  input  pwr_e       pwr_i,
  input  logic       am_i,
  input  logic       tx_i,
  input  logic       k_rx_i,
  input  logic       demod_i,
  output logic       k_req_o,
  output logic       dout_o,
  output logic       rx_o,
  output logic [1:0] ant_o
);
  ant_e ant_sel;

  always_comb begin
    k_req_o = 1'b0;
    dout_o  = 1'b0;
    rx_o    = 1'b0;
    ant_sel = ANT_OFF;
    unique case (topo_i)
      TOPO_SINGLE: begin
        k_req_o = !demod_i;
        ant_sel = ANT_ON;
      end
      TOPO_TWO: begin
        unique case (pwr_i)
          PWR_RUN: begin
            k_req_o = !demod_i;
            ant_sel = am_i ? ANT_ON : ANT_OFF;
          end
          PWR_ACK: begin
            k_req_o = 1'b1;
            ant_sel = ANT_OFF;
          end
          default: begin
            k_req_o = 1'b0;
            ant_sel = ANT_PARK;
          end
        endcase
      end
      default: begin
        rx_o = k_rx_i;
        if (pwr_i == PWR_RUN) begin
          dout_o  = demod_i;
          k_req_o = tx_i;
          ant_sel = am_i ? ANT_ON : ANT_OFF;
        end else begin
          ant_sel = ANT_FREEZE;
        end
      end
    endcase
  end

  assign ant_o = ant_sel;
endmodule

// File: rtl/kbus_kline_guard.sv
module kbus_kline_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic k_req_i,
  input  logic fault_i,
  output logic k_drive_o
);
  logic lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        lock_q <= 1'b0;
    else if (fault_i)  lock_q <= 1'b1;
    else if (!k_req_i) lock_q <= 1'b0;
  end

  assign k_drive_o = k_req_i && !lock_q && !fault_i;

  AST_FAULT_CUTS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |-> !k_drive_o); // R8
  AST_NO_RESUME_WITHOUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fault_i) && !fault_i && $past(k_req_i) && k_req_i) |-> !k_drive_o); // R8
endmodule

// File: rtl/kbus_pin_router.sv
module kbus_pin_router
  import kbus_rtr_pkg::*;
#(
  parameter int STBY_CYC = 16256,
  parameter int ACK_CYC  = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode1_i,
  input  logic       mode2_i,
  input  logic       am_i,
  input  logic       tx_i,
  input  logic       k_rx_i,
  input  logic       demod_i,
  input  logic       therm_fault_i,
  output logic       k_drive_o,
  output logic       dout_o,
  output logic       rx_o,
  output logic [1:0] ant_mode_o,
  output logic       stby_o,
  output logic       wake_o
);
  topo_e topo;
  pwr_e  pwr;
  logic  k_req;

  kbus_topo_decode u_decode (
    .mode1_i (mode1_i),
    .mode2_i (mode2_i),
    .topo_o  (topo)
  );

  kbus_power_fsm #(.STBY_CYC(STBY_CYC), .ACK_CYC(ACK_CYC)) u_power (
    .clk       (clk),
    .rst_n     (rst_n),
    .topo_i    (topo),
    .am_i      (am_i),
    .run_req_i (mode2_i),
    .pwr_o     (pwr),
    .wake_o    (wake_o)
  );

  kbus_pin_mux u_mux (
    .topo_i  (topo),
    .pwr_i   (pwr),
    .am_i    (am_i),
    .tx_i    (tx_i),
    .k_rx_i  (k_rx_i),
    .demod_i (demod_i),
    .k_req_o (k_req),
    .dout_o  (dout_o),
    .rx_o    (rx_o),
    .ant_o   (ant_mode_o)
  );

  kbus_kline_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .k_req_i   (k_req),
    .fault_i   (therm_fault_i),
    .k_drive_o (k_drive_o)
  );

  assign stby_o = (pwr == PWR_SLEEP);

  AST_BUS_TOPO_QUIET_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !mode1_i |-> (!dout_o && !rx_o)); // R2
  AST_TWO_SLEEP_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_o && !mode1_i && mode2_i) |-> (ant_mode_o == 2'd2 && !k_drive_o)); // R5
  AST_MCU_SLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_o && mode1_i) |-> (!dout_o && !k_drive_o && ant_mode_o == 2'd3 && rx_o == k_rx_i)); // R7
  AST_MCU_RX_FOLLOWS_K: assert property (@(posedge clk) disable iff (!rst_n)
    mode1_i |-> (rx_o == k_rx_i)); // R6
endmodule

// File: tb/test_kbus_pin_router.sv
module test_kbus_pin_router;
  localparam int STB  = 40;
  localparam int ACKN = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode1 = 1'b0, mode2 = 1'b0, am = 1'b1, tx = 1'b0, krx = 1'b1, demod = 1'b1, therm = 1'b0;
  logic k_drive, dout, rx, stby, wake;
  logic [1:0] ant;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit cmp_en = 0;

  // behavioural model state
  int ms = 0;        // 0 run, 1 acknowledge, 2 standby
  int mcnt = 0;
  int mprev_topo = 0;
  bit mam_prev = 1;
  bit mlock = 0;
  bit mwake = 0;

  always #5 clk = ~clk;

  kbus_pin_router #(.STBY_CYC(STB), .ACK_CYC(ACKN)) i_kbus_pin_router (
    .clk(clk), .rst_n(rst_n), .mode1_i(mode1), .mode2_i(mode2), .am_i(am),
    .tx_i(tx), .k_rx_i(krx), .demod_i(demod), .therm_fault_i(therm),
    .k_drive_o(k_drive), .dout_o(dout), .rx_o(rx), .ant_mode_o(ant),
    .stby_o(stby), .wake_o(wake)
  );

  function automatic int topo_of(bit m1, bit m2);
    if (m1) return 2;
    return m2 ? 1 : 0;
  endfunction

  function automatic bit req_of(int t, int s);
    if (t == 0) return !demod;
    if (t == 1) return (s == 0) ? !demod : (s == 1);
    return (s == 0) ? tx : 1'b0;
  endfunction

  function automatic int ant_of(int t, int s);
    if (t == 0) return 1;
    if (s == 0) return am ? 1 : 0;
    if (t == 1) return (s == 1) ? 0 : 2;
    return 3;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mcnt = 0; mprev_topo = 0; mam_prev = 1; mlock = 0; mwake = 0;
    end else begin
      int t;
      bit r;
      int ns;
      t = topo_of(mode1, mode2);
      r = req_of(t, ms);
      ns = ms;
      mwake = 0;
      if (ms != 0 && t != mprev_topo) begin
        ns = 0; mcnt = 0;
      end else if (ms == 0) begin
        if (t == 1 && !am) begin
          mcnt++;
          if (mcnt == STB) begin ns = 1; mcnt = 0; end
        end else begin
          mcnt = 0;
          if (t == 2 && !mode2) ns = 2;
        end
      end else if (ms == 1) begin
        mcnt++;
        if (mcnt == ACKN) begin ns = 2; mcnt = 0; end
      end else begin
        if ((t == 1 && am && !mam_prev) || (t == 2 && mode2)) begin
          ns = 0; mwake = 1;
        end
      end
      if (therm) mlock = 1;
      else if (!r) mlock = 0;
      ms = ns;
      mprev_topo = t;
      mam_prev = am;
    end
  end

  // compare every output against the model in every cycle
  always @(negedge clk) begin
    #1;
    if (cmp_en) begin
      int t;
      t = topo_of(mode1, mode2);
      chk("R3 R4 R5 R6 R7 R8 k_drive", k_drive, req_of(t, ms) && !mlock && !therm);
      chk("R2 R6 R7 dout", dout, (t == 2 && ms == 0) ? demod : 0);
      chk("R2 R6 R7 rx", rx, (t == 2) ? krx : 0);
      chk("R1 R3 R5 R7 ant_mode", ant, ant_of(t, ms));
      chk("R4 R5 R7 stby", stby, ms == 2);
      chk("R9 wake", wake, mwake);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
    #2;
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    cmp_en = 1;
    step(1);
    // reset state, single-wire topology
    chk("R1 reset ant_mode", ant, 1);
    chk("R9 reset stby", stby, 0);
    chk("R3 reset k_drive demod=1", k_drive, 0);

    // R1 R2 R3: single-wire topology, tx must not matter
    for (int i = 0; i < 8; i++) begin
      demod = i[0]; tx = i[1]; am = i[2]; krx = ~i[0];
      step(1);
      chk("R2 tx ignored dout", dout, 0);
      chk("R3 single k follows data", k_drive, !demod);
    end

    // R3 two-wire run: antenna follows am
    mode2 = 1; am = 1;
    for (int i = 0; i < 6; i++) begin
      demod = i[0]; am = !i[1]; tx = i[2];
      step(1);
      chk("R3 two ant follows am", ant, am ? 1 : 0);
      chk("R2 two rx low", rx, 0);
    end

    // R4 boundary: one edge short of the limit
    am = 1; step(2);
    am = 0; step(STB - 1);
    am = 1; step(2);
    chk("R4 short low run stays running", stby, 0);
    chk("R4 no acknowledge after short run", k_drive, !demod);

    // R4 full request: acknowledge then standby
    demod = 1;
    am = 0; step(STB);
    chk("R4 acknowledge drives K", k_drive, 1);
    am = 1; step(1);
    chk("R4 am edge during acknowledge ignored", stby, 0);
    am = 0; step(ACKN - 2);
    chk("R4 acknowledge still active", k_drive, 1);
    step(1);
    chk("R5 standby entered", stby, 1);
    chk("R5 drivers parked", ant, 2);
    tx = 1; step(3);
    chk("R2 tx ignored in standby", k_drive, 0);
    am = 1; step(1);
    chk("R9 wake clears standby", stby, 0);
    chk("R9 wake pulse", wake, 1);
    step(1);
    chk("R9 wake pulse single", wake, 0);

    // R6 microcontroller topology
    mode1 = 1; mode2 = 1;
    for (int i = 0; i < 8; i++) begin
      tx = i[0]; demod = i[1]; krx = i[2]; am = !i[0];
      step(1);
      chk("R6 dout follows data", dout, demod);
      chk("R6 k follows tx", k_drive, tx);
      chk("R6 rx follows K", rx, krx);
    end

    // R7 standby by mode2
    am = 1; tx = 1; mode2 = 0; step(1);
    chk("R7 standby entered", stby, 1);
    chk("R7 drivers frozen", ant, 3);
    chk("R7 tx disabled", k_drive, 0);
    krx = 0; demod = 1; step(1);
    chk("R7 rx monitors K", rx, 0);
    chk("R7 dout low", dout, 0);
    mode2 = 1; step(1);
    chk("R9 wake after mode2 high", wake, 1);

    // R8 thermal latch
    tx = 1; step(2);
    therm = 1; #1;
    chk("R8 fault cuts drive", k_drive, 0);
    step(3);
    therm = 0; step(3);
    chk("R8 stays off until off command", k_drive, 0);
    tx = 0; step(1);
    tx = 1; step(1);
    chk("R8 re-enabled after off-on", k_drive, 1);

    // back to single wire
    mode1 = 0; mode2 = 0; step(4);

    cmp_en = 0;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule